// File: doc/BRIEF.md
# 1-Wire bus master timing engine

This block generates the bit-level waveforms of a 1-Wire bus master on a single open-drain data line. An internal prescaler turns the system clock into a one-microsecond tick, and every time slot is assembled from whole microsecond counts: a low phase, an optional sample point and a fixed slot end. A host issues one operation at a time: a bus reset that reports whether any device answered, a single written bit, a single read bit, or an eight-bit transfer in either direction. Bits within a byte go out and come in least significant first.

The host sees a busy level and a one-cycle done pulse. Read data and the presence result stay valid until a later operation replaces them. For devices that draw parasitic power, the host can arm a strong pullup before a byte write, with a hold time in milliseconds. The pullup then comes on in the last bit of that write, once the line has been let go, and stays on for the requested time before the operation completes. The request is used once and then dropped.

Top module: `ow_line_master`

## Requirements
- R1: After synchronous reset, busy, done, drive_low, strong_pu, presence and rd_data are all 0.
- R2: With cmd_op=1 and cmd_data[0]=1, the block makes a write-1 slot. drive_low is high for 6 us (6*CLK_PER_US clock cycles from the accepting edge) and then released for 64 us. done pulses 70 us after acceptance.
- R3: With cmd_op=1 and cmd_data[0]=0, the block makes a write-0 slot. drive_low is high for 60 us and then released for 10 us. done pulses 70 us after acceptance.
- R4: cmd_op=2 makes a read slot. drive_low is high for 6 us, line_in is sampled 15 us after slot start (9 us after release), and the slot ends at 70 us. rd_data becomes {7'b0, sampled level}.
- R5: cmd_op=0 makes a reset. drive_low is high for 500 us, line_in is sampled 570 us after start, and done pulses at 1000 us. presence becomes 1 when the sample was low and 0 when it was high. presence changes only at a done pulse.
- R6: cmd_op=3 runs eight back-to-back 70 us slots with no gap. With cmd_dir=0 it writes cmd_data, bit 0 first. With cmd_dir=1 it uses read slots and assembles rd_data with the first sampled bit in bit 0.
- R7: A pu_set pulse with a nonzero pu_ms while idle arms the strong pullup. The next byte write (cmd_op=3, cmd_dir=0) raises strong_pu in slot 8 as soon as drive_low falls. strong_pu then holds for pu_ms*US_PER_MS us after that slot ends. done follows, with strong_pu low. The request is then cleared.
- R8: A pu_set pulse with pu_ms=0 cancels a pending pullup request.
- R9: A pending pullup request survives reset, bit and byte-read operations. Only a byte write consumes it.
- R10: strong_pu and drive_low are never high in the same cycle.
- R11: busy is high from the accepting edge until the done pulse. done lasts one cycle. cmd_valid while busy is ignored. rd_data holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Operation request, taken when busy is low |
| cmd_op | input | 2 | 0 reset, 1 write bit, 2 read bit, 3 byte transfer |
| cmd_dir | input | 1 | Byte transfer direction: 0 write, 1 read |
| cmd_data | input | 8 | Bit to write in [0], or byte to write |
| pu_set | input | 1 | Arm (nonzero pu_ms) or cancel (zero) strong pullup, taken when idle |
| pu_ms | input | PU_W | Strong pullup hold time in milliseconds |
| line_in | input | 1 | Sensed level of the data line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_data | output | 8 | Last read bit or byte |
| presence | output | 1 | Device answered the last reset |
| drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| strong_pu | output | 1 | Strong pullup enable |

## Verification
The assertions check, on every cycle, the properties that need no slot arithmetic. The pullup and the low drive never overlap. The line is driven only while busy. done lasts a single cycle and ends busy. Results and presence move only on done. The exact slot geometry can only be shown by the bench scenarios: low widths of 6, 60 and 500 us, sample points at 15 and 570 us, back-to-back byte slots, and the pullup window with its millisecond tail. The bench compares a computed expected waveform cycle by cycle against those scenarios. It also feeds device responses into the line, which shows bit ordering, presence polarity and the one-shot pullup rules.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WBIT  = 2'd1,
    OP_RBIT  = 2'd2,
    OP_BYTE  = 2'd3
  } ow_op_e;

  typedef enum logic [1:0] {
    SL_W0  = 2'd0,
    SL_W1  = 2'd1,
    SL_RD  = 2'd2,
    SL_RST = 2'd3
  } ow_slot_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_PULL = 2'd2
  } ow_state_e;
endpackage

// File: rtl/ow_tick.sv
module ow_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pc <= '0;
    end else if (run) begin
      pc <= (pc == LAST) ? '0 : pc + PW'(1);
    end
  end

  assign tick = run && (pc == LAST);
endmodule

// File: rtl/ow_slot.sv
module ow_slot
  import ow_pkg::*;
#(
  parameter int UW        = 10,
  parameter int T_W1_LOW  = 6,
  parameter int T_W0_LOW  = 60,
  parameter int T_RD_LOW  = 6,
  parameter int T_RD_SMP  = 15,
  parameter int T_BIT_END = 70,
  parameter int T_RST_LOW = 500,
  parameter int T_RST_SMP = 570,
  parameter int T_RST_END = 1000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  ow_slot_e start_kind,
  input  logic     tick,
  input  logic     line_in,
  output logic     active,
  output logic     drive_low,
  output logic     smp_ev,
  output logic     smp_val,
  output logic     slot_end
);
  ow_slot_e      kind_q;
  logic [UW-1:0] ucnt;
  logic [UW-1:0] ucnt_inc;
  logic [UW-1:0] cur_low;
  logic [UW-1:0] cur_end;
  logic [UW-1:0] cur_smp;
  logic          has_smp;

  always_comb begin
    case (kind_q)
      SL_W0: begin
        cur_low = UW'(T_W0_LOW);  cur_end = UW'(T_BIT_END);
        cur_smp = '0;             has_smp = 1'b0;
      end
      SL_W1: begin
        cur_low = UW'(T_W1_LOW);  cur_end = UW'(T_BIT_END);
        cur_smp = '0;             has_smp = 1'b0;
      end
      SL_RD: begin
        cur_low = UW'(T_RD_LOW);  cur_end = UW'(T_BIT_END);
        cur_smp = UW'(T_RD_SMP);  has_smp = 1'b1;
      end
      default: begin
        cur_low = UW'(T_RST_LOW); cur_end = UW'(T_RST_END);
        cur_smp = UW'(T_RST_SMP); has_smp = 1'b1;
      end
    endcase
  end

  assign ucnt_inc = ucnt + UW'(1);
  assign slot_end = active && tick && (ucnt_inc == cur_end);
  assign smp_ev   = active && tick && has_smp && (ucnt_inc == cur_smp);
  assign smp_val  = line_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      ucnt      <= '0;
      kind_q    <= SL_W1;
      drive_low <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      ucnt      <= '0;
      kind_q    <= start_kind;
      drive_low <= 1'b1;
    end else if (slot_end) begin
      active    <= 1'b0;
      ucnt      <= '0;
      drive_low <= 1'b0;
    end else if (active && tick) begin
      ucnt      <= ucnt_inc;
      drive_low <= (ucnt_inc < cur_low);
    end
  end
endmodule

// File: rtl/ow_seq.sv
module ow_seq
  import ow_pkg::*;
#(
  parameter int US_PER_MS = 1000,
  parameter int PU_W      = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_dir,
  input  logic [7:0]      cmd_data,
  input  logic            pu_set,
  input  logic [PU_W-1:0] pu_ms,
  input  logic            tick,
  input  logic            slot_end,
  input  logic            smp_ev,
  input  logic            smp_val,
  input  logic            drive_low,
  output logic            start,
  output ow_slot_e        start_kind,
  output logic            busy,
  output logic            pull_run,
  output logic            done,
  output logic [7:0]      rd_data,
  output logic            presence,
  output logic            strong_pu
);
  localparam int MW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [MW-1:0] US_LAST = MW'(US_PER_MS - 1);

  ow_state_e       state;
  ow_op_e          op_q;
  ow_op_e          op_in;
  logic            dir_q;
  logic [7:0]      sh;
  logic [7:0]      rsh;
  logic [2:0]      bidx;
  logic            arm;
  logic [PU_W-1:0] arm_len;
  logic            pu_use;
  logic [PU_W-1:0] pu_len;
  logic            pu_phase;
  logic [MW-1:0]   us_cnt;
  logic [PU_W-1:0] ms_cnt;
  logic            accept;
  logic            more;
  logic            pu_take;

  assign op_in   = ow_op_e'(cmd_op);
  assign accept  = cmd_valid && (state == ST_IDLE);
  assign more    = (op_q == OP_BYTE) && (bidx != 3'd7);
  assign start   = accept || ((state == ST_SLOT) && slot_end && more);
  assign pu_take = arm && (op_in == OP_BYTE) && !cmd_dir;

  always_comb begin
    if (accept) begin
      case (op_in)
        OP_RESET: start_kind = SL_RST;
        OP_RBIT:  start_kind = SL_RD;
        OP_WBIT:  start_kind = cmd_data[0] ? SL_W1 : SL_W0;
        default:  start_kind = cmd_dir ? SL_RD : (cmd_data[0] ? SL_W1 : SL_W0);
      endcase
    end else begin
      start_kind = dir_q ? SL_RD : (sh[1] ? SL_W1 : SL_W0);
    end
  end

  assign busy      = (state != ST_IDLE);
  assign pull_run  = (state == ST_PULL);
  assign strong_pu = pu_phase && !drive_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= OP_RESET;
      dir_q    <= 1'b0;
      sh       <= '0;
      rsh      <= '0;
      bidx     <= '0;
      arm      <= 1'b0;
      arm_len  <= '0;
      pu_use   <= 1'b0;
      pu_len   <= '0;
      pu_phase <= 1'b0;
      us_cnt   <= '0;
      ms_cnt   <= '0;
      done     <= 1'b0;
      rd_data  <= '0;
      presence <= 1'b0;
    end else begin
      done <= 1'b0;
      if ((state == ST_IDLE) && pu_set) begin
        arm     <= (pu_ms != '0);
        arm_len <= pu_ms;
      end
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            state  <= ST_SLOT;
            op_q   <= op_in;
            dir_q  <= (op_in == OP_BYTE) && cmd_dir;
            sh     <= cmd_data;
            bidx   <= '0;
            pu_use <= pu_take;
            pu_len <= arm_len;
            if (pu_take) arm <= 1'b0;
          end
        end
        ST_SLOT: begin
          if (smp_ev) rsh <= {smp_val, rsh[7:1]};
          if (slot_end) begin
            if (more) begin
              bidx <= bidx + 3'd1;
              sh   <= {1'b0, sh[7:1]};
              if (pu_use && (bidx == 3'd6)) pu_phase <= 1'b1;
            end else if (pu_use) begin
              state  <= ST_PULL;
              us_cnt <= '0;
              ms_cnt <= '0;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
              case (op_q)
                OP_RESET: presence <= ~rsh[7];
                OP_RBIT:  rd_data  <= {7'b0, rsh[7]};
                OP_BYTE:  if (dir_q) rd_data <= rsh;
                default:  ;
              endcase
            end
          end
        end
        ST_PULL: begin
          if (tick) begin
            if (us_cnt == US_LAST) begin
              us_cnt <= '0;
              if ((ms_cnt + PU_W'(1)) == pu_len) begin
                state    <= ST_IDLE;
                done     <= 1'b1;
                pu_phase <= 1'b0;
                pu_use   <= 1'b0;
              end else begin
                ms_cnt <= ms_cnt + PU_W'(1);
              end
            end else begin
              us_cnt <= us_cnt + MW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_line_master.sv
module ow_line_master
  import ow_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int US_PER_MS  = 1000,
  parameter int PU_W       = 8,
  parameter int T_W1_LOW   = 6,
  parameter int T_W0_LOW   = 60,
  parameter int T_RD_LOW   = 6,
  parameter int T_RD_SMP   = 15,
  parameter int T_BIT_END  = 70,
  parameter int T_RST_LOW  = 500,
  parameter int T_RST_SMP  = 570,
  parameter int T_RST_END  = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_dir,
  input  logic [7:0]      cmd_data,
  input  logic            pu_set,
  input  logic [PU_W-1:0] pu_ms,
  input  logic            line_in,
  output logic            busy,
  output logic            done,
  output logic [7:0]      rd_data,
  output logic            presence,
  output logic            drive_low,
  output logic            strong_pu
);
  localparam int UW = $clog2(T_RST_END + 1);

  logic     tick;
  logic     start;
  ow_slot_e start_kind;
  logic     slot_active;
  logic     pull_run;
  logic     smp_ev;
  logic     smp_val;
  logic     slot_end;

  ow_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (slot_active || pull_run),
    .tick    (tick)
  );

  ow_slot #(
    .UW(UW), .T_W1_LOW(T_W1_LOW), .T_W0_LOW(T_W0_LOW), .T_RD_LOW(T_RD_LOW),
    .T_RD_SMP(T_RD_SMP), .T_BIT_END(T_BIT_END), .T_RST_LOW(T_RST_LOW),
    .T_RST_SMP(T_RST_SMP), .T_RST_END(T_RST_END)
  ) u_slot (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_kind (start_kind),
    .tick       (tick),
    .line_in    (line_in),
    .active     (slot_active),
    .drive_low  (drive_low),
    .smp_ev     (smp_ev),
    .smp_val    (smp_val),
    .slot_end   (slot_end)
  );

  ow_seq #(.US_PER_MS(US_PER_MS), .PU_W(PU_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_dir    (cmd_dir),
    .cmd_data   (cmd_data),
    .pu_set     (pu_set),
    .pu_ms      (pu_ms),
    .tick       (tick),
    .slot_end   (slot_end),
    .smp_ev     (smp_ev),
    .smp_val    (smp_val),
    .drive_low  (drive_low),
    .start      (start),
    .start_kind (start_kind),
    .busy       (busy),
    .pull_run   (pull_run),
    .done       (done),
    .rd_data    (rd_data),
    .presence   (presence),
    .strong_pu  (strong_pu)
  );
endmodule

// File: rtl/ow_line_master_chk.sv
module ow_line_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic [7:0] rd_data,
  input logic       presence,
  input logic       drive_low,
  input logic       strong_pu
);
  AST_PU_NOT_WITH_LOW: assert property (@(posedge clk) disable iff (rst) !(strong_pu && drive_low)); // R10
  AST_PU_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) strong_pu |-> busy); // R7
  AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) drive_low |-> busy); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R11
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(rd_data)); // R11
  AST_PRESENCE_HELD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(presence)); // R5
endmodule

bind ow_line_master ow_line_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data),
  .presence  (presence),
  .drive_low (drive_low),
  .strong_pu (strong_pu)
);

// File: tb/ow_line_master_bench.sv
`timescale 1ns/1ps
module ow_line_master_bench;
  localparam int C    = 2;
  localparam int UPM  = 4;
  localparam int PU_W = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = 2'd0;
  logic            cmd_dir = 1'b0;
  logic [7:0]      cmd_data = 8'h00;
  logic            pu_set = 1'b0;
  logic [PU_W-1:0] pu_ms = '0;
  logic            dev_low = 1'b0;
  logic            line_in;
  logic            busy, done, presence, drive_low, strong_pu;
  logic [7:0]      rd_data;

  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  assign line_in = ~(drive_low | dev_low);

  ow_line_master #(.CLK_PER_US(C), .US_PER_MS(UPM), .PU_W(PU_W)) u_ow_line_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dir(cmd_dir),
    .cmd_data(cmd_data), .pu_set(pu_set), .pu_ms(pu_ms), .line_in(line_in),
    .busy(busy), .done(done), .rd_data(rd_data), .presence(presence),
    .drive_low(drive_low), .strong_pu(strong_pu)
  );

  task automatic check_val(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic arm_pu(input int ms);
    @(negedge clk);
    pu_set = 1'b1;
    pu_ms  = PU_W'(ms);
    @(negedge clk);
    pu_set = 1'b0;
  endtask

  // One operation, compared cycle by cycle with a waveform computed here.
  task automatic run_op(input string tag, input logic [1:0] op, input logic dir,
                        input logic [7:0] data, input int pu_exp,
                        input logic [7:0] dev_bits, input logic dev_present,
                        input bit poke);
    int  nsl, len, period, total, s, t, lowt;
    bit  bad, rd, e_low, e_spu, e_busy, e_done;
    nsl    = (op == 2'd3) ? 8 : 1;
    len    = (op == 2'd0) ? 1000 : 70;
    period = len * C;
    total  = nsl * period + pu_exp * UPM * C;
    rd     = (op == 2'd2) || (op == 2'd3 && dir);
    bad    = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dir = dir; cmd_data = data;
    @(posedge clk);
    for (int j = 0; j <= total; j++) begin
      @(negedge clk);
      if (j == 0) cmd_valid = 1'b0;
      // R11: a request while busy must leave the waveform untouched
      if (poke && j == 40) begin cmd_valid = 1'b1; cmd_op = 2'd1; cmd_data = 8'h00; end
      if (poke && j == 41) cmd_valid = 1'b0;
      s = 0; t = 0;
      if (j < nsl * period) begin
        s = j / period;
        t = (j % period) / C;
        if (op == 2'd0) lowt = 500;
        else if (rd) lowt = 6;
        else lowt = data[s] ? 6 : 60;
        e_low = (t < lowt);
        e_spu = (pu_exp > 0) && (s == 7) && !e_low;
      end else begin
        e_low = 1'b0;
        e_spu = (j < total);
      end
      e_busy = (j < total);
      e_done = (j == total);
      // R10: the model never has pullup and low drive together
      if (!bad && (drive_low !== e_low || strong_pu !== e_spu ||
                   busy !== e_busy || done !== e_done)) begin
        bad = 1'b1;
        $display("FAIL %s: cycle %0d got low=%b spu=%b busy=%b done=%b expected low=%b spu=%b busy=%b done=%b",
                 tag, j, drive_low, strong_pu, busy, done, e_low, e_spu, e_busy, e_done);
      end
      dev_low = 1'b0;
      if (j < nsl * period) begin
        if (rd && !dev_bits[s] && t >= 6 && t < 30) dev_low = 1'b1;
        if (op == 2'd0 && dev_present && t >= 560 && t < 680) dev_low = 1'b1;
      end
    end
    dev_low = 1'b0;
    nvec++;
    if (bad) nfail++;
    // R11: no operation starts from the ignored request
    repeat (3) @(negedge clk);
    check_val({tag, " idle after done"}, {busy, drive_low}, 0);
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] wr_vals [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    logic [7:0] rd_vals [4] = '{8'h5A, 8'h01, 8'h80, 8'hC3};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_val("R1 outputs", {busy, done, drive_low, strong_pu, presence, rd_data}, 0);

    run_op("R2 write-1", 2'd1, 1'b0, 8'h01, 0, 8'h00, 1'b0, 1'b0);
    run_op("R3 write-0", 2'd1, 1'b0, 8'h00, 0, 8'h00, 1'b0, 1'b1);

    run_op("R4 read high", 2'd2, 1'b0, 8'h00, 0, 8'h01, 1'b0, 1'b0);
    check_val("R4 rd_data high", rd_data, 8'h01);
    run_op("R4 read low", 2'd2, 1'b0, 8'h00, 0, 8'h00, 1'b0, 1'b0);
    check_val("R4 rd_data low", rd_data, 8'h00);

    run_op("R5 reset present", 2'd0, 1'b0, 8'h00, 0, 8'h00, 1'b1, 1'b0);
    check_val("R5 presence 1", presence, 1);
    run_op("R5 reset absent", 2'd0, 1'b0, 8'h00, 0, 8'h00, 1'b0, 1'b1);
    check_val("R5 presence 0", presence, 0);

    for (int i = 0; i < 4; i++) begin
      run_op("R6 byte write", 2'd3, 1'b0, wr_vals[i], 0, 8'h00, 1'b0, i == 2);
    end
    for (int i = 0; i < 4; i++) begin
      run_op("R6 byte read", 2'd3, 1'b1, 8'h00, 0, rd_vals[i], 1'b0, 1'b0);
      check_val("R6 byte value", rd_data, rd_vals[i]);
    end

    // R11: results held across write operations
    run_op("R11 write keeps data", 2'd3, 1'b0, 8'h96, 0, 8'h00, 1'b0, 1'b0);
    check_val("R11 rd_data held", rd_data, rd_vals[3]);

    // R7 armed write, then consumed
    arm_pu(3);
    run_op("R7 pullup write", 2'd3, 1'b0, 8'h81, 3, 8'h00, 1'b0, 1'b0);
    run_op("R7 pullup consumed", 2'd3, 1'b0, 8'h7E, 0, 8'h00, 1'b0, 1'b0);
    arm_pu(2);
    run_op("R7 pullup bit7 one", 2'd3, 1'b0, 8'h80, 2, 8'h00, 1'b0, 1'b0);

    // R8 cancel
    arm_pu(2);
    arm_pu(0);
    run_op("R8 cancelled", 2'd3, 1'b0, 8'hC3, 0, 8'h00, 1'b0, 1'b0);

    // R9 request survives other operations
    arm_pu(1);
    run_op("R9 reset keeps arm", 2'd0, 1'b0, 8'h00, 0, 8'h00, 1'b1, 1'b0);
    run_op("R9 bit keeps arm", 2'd1, 1'b0, 8'h00, 0, 8'h00, 1'b0, 1'b0);
    run_op("R9 read byte keeps arm", 2'd3, 1'b1, 8'h00, 0, 8'h33, 1'b0, 1'b0);
    run_op("R9 write uses arm", 2'd3, 1'b0, 8'h11, 1, 8'h00, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule